// File: doc/BRIEF.md
# Narrow-Bus External Memory Write Engine

This block takes 24-bit words from a processor and writes each one to an external static RAM over an 8-bit data bus. The RAM needs no wait states. The word goes out as a short run of byte cycles, most significant byte first. Each byte cycle has a fixed four-clock shape, and the byte address rises by one from byte to byte. A mode field sets how many bytes of each word reach the bus: three, two or one. The same field can also switch the engine off.

The external address is the sum of three terms: a programmable base address, a write offset and the byte index. When a word finishes, the offset moves forward by the number of bytes written, so the next word follows the last one in memory. Offering a word on the input stream is the only way to start a transfer. The timing never varies, so software can pace its writes by counting clocks instead of polling status.

The input stream uses valid/ready. `in_ready` is low in four cases: the mode is off, the stop input is high, the wait input is high, or the one-entry pending buffer is full. A word offered while `in_ready` is low is discarded. If the engine is enabled and neither low-power input is high, the discard also sets a sticky overrun flag, because software paced too fast. The stop input aborts the current transfer, flushes all queued words and clears both status flags. The base, offset and mode registers keep their values. The wait input refuses new words but lets the current word and any pending word finish at normal speed.

Top module: `nbw_write_engine`

## Requirements
- R1: A word is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the mode is nonzero, `stop_req` is low, `wait_req` is low and the pending buffer is empty.
- R2: The mode (`cfg_sel` = 2, low bits of `cfg_wdata`) selects the bytes written per word. Mode 1 writes three bytes: bits 23:16, then 15:8, then 7:0. Mode 2 writes two bytes: bits 15:8, then 7:0. Mode 3 writes one byte: bits 7:0. In mode 0 offered words are ignored and no bus cycle occurs.
- R3: Every byte cycle lasts 4 clocks. `ext_cs_n` is low in all four. `ext_we_n` is low in the second and third clocks only. Address and data do not change while the strobe is low.
- R4: The address of byte k of a word is base (`cfg_sel` = 0) + offset (`cfg_sel` = 1) + k, modulo 2^ADDR_W.
- R5: When a word completes, the offset increases by the number of bytes that word wrote.
- R6: A word taken at edge A on an idle engine drops `ext_we_n` for byte k at edge A+1+4k. One word takes 4 clocks per byte, which is 12 clocks in mode 1. A pending word starts in the clock right after the previous word ends, with no gap.
- R7: A single-entry pending buffer holds one word during a transfer. `stat_busy` is high while a word is in transfer or pending, and low otherwise.
- R8: A word offered while the pending buffer is full (engine enabled, no stop, no wait) is discarded. `stat_overrun` is then set and stays set until stop or reset.
- R9: While `stop_req` is high, the transfer aborts, queued words are discarded, the offset does not advance, `stat_busy` and `stat_overrun` read 0, the bus is idle and no word is taken. The mode, base and offset registers keep their values.
- R10: While `wait_req` is high, no new word is taken and `stat_overrun` does not change. A word in transfer and a pending word complete with R6 timing.
- R11: After reset, the mode is 0, both status flags are 0, `ext_cs_n` and `ext_we_n` are high and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 offset, 2 mode |
| cfg_wdata | input | ADDR_W | Register write value |
| in_valid | input | 1 | Input word offered |
| in_data | input | DATA_W | Input word |
| in_ready | output | 1 | Engine will take an offered word |
| stop_req | input | 1 | Stop: hold engine in its reset state |
| wait_req | input | 1 | Wait: finish queued work, take nothing new |
| ctrl_mode | output | MODE_W | Current mode field |
| stat_busy | output | 1 | Word in transfer or pending |
| stat_overrun | output | 1 | Sticky flag: word discarded while buffer full |
| ext_cs_n | output | 1 | External chip select, active low |
| ext_we_n | output | 1 | External write strobe, active low |
| ext_addr | output | ADDR_W | External byte address |
| ext_data | output | BUS_W | External byte data |

## Verification
The assertions check, on every cycle: the strobe width, that the strobe stays inside chip select, that address and data hold still during the strobe, that the bus is idle whenever the engine is not busy, that stop clears the engine, that overrun is set by a refused offer and then stays set, and that wait lowers ready. Some behaviour needs the bench's scenarios, which compare each strobe against an arithmetic model: byte order and lane selection in each mode, address formation, offset advance between words, exact strobe edges for back-to-back words, the offset left unchanged after a stop, and the completion of queued words during wait.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
  typedef enum logic [1:0] {
    SEL_BASE   = 2'd0,
    SEL_OFFSET = 2'd1,
    SEL_MODE   = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/nbw_regs.sv
module nbw_regs
  import nbw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MODE_W = 2,
  parameter int NB_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              word_done,
  input  logic [NB_W-1:0]   done_nb,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] offset_q,
  output logic [MODE_W-1:0] mode_q
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      offset_q <= '0;
      mode_q   <= '0;
    end else begin
      if (cfg_we && sel == SEL_BASE) base_q <= cfg_wdata;
      if (cfg_we && sel == SEL_MODE) mode_q <= cfg_wdata[MODE_W-1:0];
      if (cfg_we && sel == SEL_OFFSET)
        offset_q <= cfg_wdata;
      else if (word_done)
        offset_q <= offset_q + ADDR_W'(done_nb);
    end
  end
endmodule

// File: rtl/nbw_queue.sv
module nbw_queue #(
  parameter int DATA_W = 24,
  parameter int NB_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              open_i,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NB_W-1:0]   in_nb,
  input  logic              word_done,
  output logic              in_ready,
  output logic              act_valid,
  output logic [DATA_W-1:0] act_word,
  output logic [NB_W-1:0]   act_nb,
  output logic              pend_valid,
  output logic              overrun
);
  logic [DATA_W-1:0] pend_word;
  logic [NB_W-1:0]   pend_nb;
  logic offer, accept, drop, act_free;

  assign in_ready = open_i && !pend_valid;
  assign offer    = in_valid && open_i;
  assign accept   = offer && !pend_valid;
  assign drop     = offer && pend_valid;
  assign act_free = !act_valid || word_done;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      act_valid  <= 1'b0;
      act_word   <= '0;
      act_nb     <= '0;
      pend_valid <= 1'b0;
      pend_word  <= '0;
      pend_nb    <= '0;
    end else if (act_free) begin
      if (pend_valid) begin
        act_valid  <= 1'b1;
        act_word   <= pend_word;
        act_nb     <= pend_nb;
        pend_valid <= 1'b0;
      end else if (accept) begin
        act_valid <= 1'b1;
        act_word  <= in_data;
        act_nb    <= in_nb;
      end else begin
        act_valid <= 1'b0;
      end
    end else if (accept) begin
      pend_valid <= 1'b1;
      pend_word  <= in_data;
      pend_nb    <= in_nb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) overrun <= 1'b0;
    else if (drop)       overrun <= 1'b1;
  end
endmodule

// File: rtl/nbw_sequencer.sv
module nbw_sequencer #(
  parameter int DATA_W     = 24,
  parameter int BUS_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int NB_W       = 2,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              act_valid,
  input  logic [DATA_W-1:0] act_word,
  input  logic [NB_W-1:0]   act_nb,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  output logic              word_done,
  output logic              ext_cs_n,
  output logic              ext_we_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [BUS_W-1:0]  ext_data
);
  localparam int MAXB   = DATA_W / BUS_W;
  localparam int PHASES = STROBE_CYC + 2;
  localparam int PH_W   = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] PH_SLO  = PH_W'(1);
  localparam logic [PH_W-1:0] PH_SHI  = PH_W'(STROBE_CYC);
  localparam logic [NB_W-1:0] NB_MAX  = NB_W'(MAXB);

  logic [PH_W-1:0]  phase;
  logic [NB_W-1:0]  idx;
  logic [NB_W-1:0]  shift;
  logic             last_byte;
  logic [BUS_W-1:0] lanes [MAXB];

  for (genvar k = 0; k < MAXB; k++) begin : g_lane
    assign lanes[k] = act_word[k*BUS_W +: BUS_W];
  end

  assign last_byte = (idx == act_nb - NB_W'(1));
  assign word_done = act_valid && !flush && phase == PH_LAST && last_byte;
  assign shift     = act_nb - NB_W'(1) - idx;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      phase <= '0;
      idx   <= '0;
    end else if (act_valid) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        idx   <= last_byte ? '0 : idx + NB_W'(1);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  always_comb begin
    ext_cs_n = !act_valid;
    ext_we_n = !(act_valid && phase >= PH_SLO && phase <= PH_SHI);
    ext_addr = base + offset + ADDR_W'(idx);
    ext_data = (shift < NB_MAX) ? lanes[shift] : '0;
  end
endmodule

// File: rtl/nbw_write_engine.sv
module nbw_write_engine #(
  parameter int DATA_W     = 24,
  parameter int BUS_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int MODE_W     = 2,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              stop_req,
  input  logic              wait_req,
  output logic [MODE_W-1:0] ctrl_mode,
  output logic              stat_busy,
  output logic              stat_overrun,
  output logic              ext_cs_n,
  output logic              ext_we_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [BUS_W-1:0]  ext_data
);
  localparam int MAXB = DATA_W / BUS_W;
  localparam int NB_W = $clog2(MAXB + 1);

  logic [ADDR_W-1:0] base_q, offset_q;
  logic [MODE_W-1:0] mode_q;
  logic [NB_W-1:0]   in_nb, act_nb;
  logic [DATA_W-1:0] act_word;
  logic act_valid, pend_valid, word_done, open_q;

  always_comb begin
    if (mode_q == '0)                in_nb = '0;
    else if (int'(mode_q) <= MAXB)   in_nb = NB_W'(MAXB + 1 - int'(mode_q));
    else                             in_nb = NB_W'(1);
  end

  assign open_q    = (in_nb != '0) && !stop_req && !wait_req;
  assign ctrl_mode = mode_q;
  assign stat_busy = act_valid || pend_valid;

  nbw_regs #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .NB_W(NB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .word_done(word_done), .done_nb(act_nb),
    .base_q(base_q), .offset_q(offset_q), .mode_q(mode_q)
  );

  nbw_queue #(.DATA_W(DATA_W), .NB_W(NB_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(stop_req), .open_i(open_q),
    .in_valid(in_valid), .in_data(in_data), .in_nb(in_nb),
    .word_done(word_done), .in_ready(in_ready), .act_valid(act_valid),
    .act_word(act_word), .act_nb(act_nb), .pend_valid(pend_valid),
    .overrun(stat_overrun)
  );

  nbw_sequencer #(.DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
                  .NB_W(NB_W), .STROBE_CYC(STROBE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .flush(stop_req), .act_valid(act_valid),
    .act_word(act_word), .act_nb(act_nb), .base(base_q), .offset(offset_q),
    .word_done(word_done), .ext_cs_n(ext_cs_n), .ext_we_n(ext_we_n),
    .ext_addr(ext_addr), .ext_data(ext_data)
  );
endmodule

// File: rtl/nbw_write_engine_chk.sv
module nbw_write_engine_chk #(
  parameter int ADDR_W     = 16,
  parameter int BUS_W      = 8,
  parameter int MODE_W     = 2,
  parameter int STROBE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_req,
  input logic              wait_req,
  input logic              in_valid,
  input logic              in_ready,
  input logic [MODE_W-1:0] ctrl_mode,
  input logic              stat_busy,
  input logic              stat_overrun,
  input logic              ext_cs_n,
  input logic              ext_we_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [BUS_W-1:0]  ext_data
);
  logic [7:0] lo_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || ext_we_n) lo_cnt <= '0;
    else                    lo_cnt <= lo_cnt + 8'd1;
  end

  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n || stop_req)
    ($rose(ext_we_n) && !$past(stop_req)) |-> lo_cnt == 8'(STROBE_CYC));
  // R3
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_we_n |-> !ext_cs_n);
  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || stop_req)
    (!ext_we_n && !$past(stop_req)) |-> ($stable(ext_addr) && $stable(ext_data)));
  // R7
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_busy |-> ext_cs_n);
  // R9
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!stat_busy && !stat_overrun && ext_cs_n && ext_we_n));
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !stop_req && !wait_req && ctrl_mode != '0) |=> stat_overrun);
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_overrun && !stop_req) |=> stat_overrun);
  // R10
  wait_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> !in_ready);
endmodule

bind nbw_write_engine nbw_write_engine_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .MODE_W(MODE_W), .STROBE_CYC(STROBE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
  .in_valid(in_valid), .in_ready(in_ready), .ctrl_mode(ctrl_mode),
  .stat_busy(stat_busy), .stat_overrun(stat_overrun), .ext_cs_n(ext_cs_n),
  .ext_we_n(ext_we_n), .ext_addr(ext_addr), .ext_data(ext_data)
);

// File: tb/nbw_write_engine_bench.sv
`timescale 1ns/1ps
module nbw_write_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic stop_req = 1'b0, wait_req = 1'b0;
  logic in_ready, stat_busy, stat_overrun, ext_cs_n, ext_we_n;
  logic [1:0] ctrl_mode;
  logic [15:0] ext_addr;
  logic [7:0] ext_data;

  nbw_write_engine u_nbw_write_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .stop_req(stop_req), .wait_req(wait_req),
    .ctrl_mode(ctrl_mode), .stat_busy(stat_busy), .stat_overrun(stat_overrun),
    .ext_cs_n(ext_cs_n), .ext_we_n(ext_we_n), .ext_addr(ext_addr),
    .ext_data(ext_data)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected strobe model
  int exp_addr [256];
  int exp_data [256];
  int exp_cyc  [256];
  int head = 0, tail = 0;
  int base_m = 0, off_m = 0, mode_m = 0, free_at = 0;

  bit prev_we = 1'b1;
  int lo_run = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_we && !ext_we_n) begin
        if (head == tail) chk(0, "R2", "unexpected strobe at addr", ext_addr, 0);
        else begin
          chk(int'(ext_addr) == exp_addr[head], "R4/R5", "byte address", ext_addr, exp_addr[head]);
          chk(int'(ext_data) == exp_data[head], "R2", "byte data", ext_data, exp_data[head]);
          chk(cyc == exp_cyc[head], "R6", "strobe edge", cyc, exp_cyc[head]);
          chk(!ext_cs_n, "R3", "select during strobe", ext_cs_n, 0);
          head++;
        end
      end
      if (!ext_we_n) lo_run++;
      else begin
        if (!prev_we) chk(lo_run == 2, "R3", "strobe length", lo_run, 2);
        lo_run = 0;
      end
      prev_we = ext_we_n;
    end
  end

  task automatic cfg(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 0) base_m = val;
    if (sel == 1) off_m = val;
    if (sel == 2) mode_m = val;
  endtask

  function automatic int nbytes(input int m);
    return (m == 0) ? 0 : 4 - m;
  endfunction

  // drives one offer in the current cycle; returns at the next negedge
  task automatic push(input int d, input bit exp_acc, input string req);
    int a, nb, start;
    in_valid = 1'b1; in_data = 24'(d);
    chk(in_ready == exp_acc, req, "ready on offer", in_ready, exp_acc);
    @(negedge clk);
    in_valid = 1'b0;
    a = cyc;
    if (exp_acc) begin
      nb = nbytes(mode_m);
      start = (a > free_at) ? a : free_at;
      for (int k = 0; k < nb; k++) begin
        exp_addr[tail] = (base_m + off_m + k) & 16'hFFFF;
        exp_data[tail] = (d >> (8 * (nb - 1 - k))) & 8'hFF;
        exp_cyc[tail]  = start + 1 + 4 * k;
        tail++;
      end
      free_at = start + 4 * nb;
      off_m = (off_m + nb) & 16'hFFFF;
    end
  endtask

  task automatic to_idle();
    int n = 0;
    while (stat_busy && n < 1000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ext_cs_n && ext_we_n, "R11", "bus idle after reset", {ext_cs_n, ext_we_n}, 3);
    chk(!stat_busy && !stat_overrun, "R11", "status after reset", {stat_busy, stat_overrun}, 0);
    chk(!in_ready && ctrl_mode == 0, "R11", "ready/mode after reset", {in_ready, ctrl_mode}, 0);

    // R2 mode 0 ignores words
    push(24'h123456, 0, "R2");
    repeat (16) @(negedge clk);
    chk(!stat_busy && !stat_overrun, "R2", "mode 0 no activity", {stat_busy, stat_overrun}, 0);

    cfg(0, 16'h1200);
    cfg(1, 16'h0010);
    for (int m = 1; m <= 3; m++) begin
      cfg(2, m);
      chk(ctrl_mode == 2'(m), "R2", "mode readback", ctrl_mode, m);
      chk(in_ready, "R1", "ready when idle", in_ready, 1);
      push(24'h0A0B0C + m * 24'h010203, 1, "R1");
      to_idle();
      for (int i = 0; i < 2; i++)
        push((24'h3C5A96 + i * 24'h111111 + m * 24'h070503) & 24'hFFFFFF, 1, "R1");
      chk(stat_busy, "R7", "busy with pending", stat_busy, 1);
      chk(!in_ready, "R7", "ready low with pending", in_ready, 0);
      to_idle();
      chk(!stat_busy, "R7", "busy clears", stat_busy, 0);
    end

    // R8 overrun
    cfg(2, 1);
    push(24'hA1B2C3, 1, "R8");
    push(24'hD4E5F6, 1, "R8");
    push(24'h778899, 0, "R8");
    chk(stat_overrun, "R8", "overrun set", stat_overrun, 1);
    to_idle();
    chk(stat_overrun, "R8", "overrun sticky", stat_overrun, 1);

    // R9 stop mid-word
    push(24'hCAFE01, 1, "R9");
    repeat (4) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    chk(!stat_busy && !stat_overrun, "R9", "status cleared", {stat_busy, stat_overrun}, 0);
    chk(ext_cs_n && ext_we_n, "R9", "bus idle in stop", {ext_cs_n, ext_we_n}, 3);
    chk(!in_ready && ctrl_mode == 1, "R9", "mode kept, ready low", {in_ready, ctrl_mode}, 1);
    head = tail; off_m = (off_m - 3) & 16'hFFFF; free_at = 0;
    @(negedge clk);
    stop_req = 1'b0;
    @(negedge clk);
    push(24'h5EED42, 1, "R9");
    to_idle();

    // R10 wait
    push(24'h246801, 1, "R10");
    push(24'h13579B, 1, "R10");
    wait_req = 1'b1;
    @(negedge clk);
    push(24'hFFFFFF, 0, "R10");
    chk(stat_busy, "R10", "queued work continues", stat_busy, 1);
    to_idle();
    chk(!stat_overrun, "R10", "overrun untouched", stat_overrun, 0);
    wait_req = 1'b0;
    @(negedge clk);
    push(24'h0F0E0D, 1, "R10");
    to_idle();

    chk(head == tail, "R6", "all expected bytes written", head, tail);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule